// File: doc/BRIEF.md
# Four-Channel Flow-Control Character Register File

This block stores the two software flow-control characters (resume and pause, conventionally Xon and Xoff) for each of four serial channels. A host port reads and writes them one at a time, addressed by channel and character type. All eight values appear on flat output buses, where each channel's transmitter and receiver character comparators can use them.

A command input gives two shortcuts. Both act only when the command names channel 0. An arm command sets up a one-shot broadcast: the next host write to channel 0's register of the armed type goes into that register on all four channels. A default-load command sets every register of one type to its standard value in a single cycle. Xon registers load 0x11 and Xoff registers load 0x13.

Top module: `xonxoff_regfile`

## Requirements
- R1: While `rst_n` is low, all eight character registers read 0x00 and both broadcast arm flags are clear. After reset, a write to channel 0 updates only channel 0.
- R2: Address encoding is `host_addr[0]` = type (0 Xon, 1 Xoff) and `host_addr[2:1]` = channel. Outside broadcast, a host write updates only the addressed register, and the new value shows on the outputs after the next rising edge. `host_rdata` returns the addressed register combinationally. Channel k occupies bits [8k+7:8k] of `xon_chars` and `xoff_chars`.
- R3: `cmd_op` encodings are 0 = arm Xon broadcast, 1 = arm Xoff broadcast, 2 = load Xon defaults, 3 = load Xoff defaults. After an arm-Xon command, the next write to address 0 sets all four Xon registers to the written byte and leaves the Xoff registers alone.
- R4: After an arm-Xoff command, the next write to address 1 sets all four Xoff registers to the written byte.
- R5: A broadcast write clears its arm flag. The next write to channel 0 updates only channel 0. If an arm command coincides with the consuming write, the flag remains set.
- R6: Writes to other addresses while a flag is armed act as individual writes. They neither fire nor cancel the broadcast. Reads have no effect on state.
- R7: The two arm flags are independent. A write to channel 0's Xoff register while only Xon is armed is an individual write and leaves the Xon arm pending.
- R8: Load-Xon sets all four Xon registers to 0x11 on the next edge. It leaves the Xoff registers and both arm flags unchanged.
- R9: Load-Xoff sets all four Xoff registers to 0x13 on the next edge.
- R10: A command with `cmd_chan` other than 0 has no effect.
- R11: When a default load and a host write target the same register in the same cycle, the load value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | {channel, type} |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| cmd_valid | input | 1 | Command strobe |
| cmd_chan | input | 2 | Channel the command is issued on |
| cmd_op | input | 2 | Command code |
| xon_chars | output | 32 | Xon characters, channel k at [8k+7:8k] |
| xoff_chars | output | 32 | Xoff characters, channel k at [8k+7:8k] |

## Verification
The bench places unrelated writes between an arm command and the channel-0 write. A design that cancels or fires the broadcast too early would leave channels 1 to 3 unchanged, or overwrite them too soon. It arms one type and then writes the other type to check that the flags are independent. It writes to channel 0 again after a broadcast to catch a flag that never clears. It issues commands on channels 1 to 3, which a design that ignores `cmd_chan` would obey. It also collides default loads with same-cycle writes and checks that a load keeps a pending arm.

// File: rtl/xonxoff_regfile.sv
module xonxoff_regfile #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_DEF = 8'h11,
  parameter logic [DW-1:0] XOFF_DEF = 8'h13,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              cmd_valid,
  input  logic [CW-1:0]     cmd_chan,
  input  logic [1:0]        cmd_op,
  output logic [NCH*DW-1:0] xon_chars,
  output logic [NCH*DW-1:0] xoff_chars
);
  localparam logic [1:0] OP_ARM_ON = 2'd0, OP_ARM_OFF = 2'd1, OP_LD_ON = 2'd2, OP_LD_OFF = 2'd3;

  logic [DW-1:0] on_q [NCH];
  logic [DW-1:0] off_q [NCH];
  logic armed_on, armed_off;

  wire          sel_off  = host_addr[0];
  wire [CW-1:0] wr_chan  = host_addr[AW-1:1];
  wire          cmd_a    = cmd_valid && (cmd_chan == '0);
  wire          arm_on   = cmd_a && (cmd_op == OP_ARM_ON);
  wire          arm_off  = cmd_a && (cmd_op == OP_ARM_OFF);
  wire          ld_on    = cmd_a && (cmd_op == OP_LD_ON);
  wire          ld_off   = cmd_a && (cmd_op == OP_LD_OFF);
  wire          a_write  = host_wr && (wr_chan == '0);
  wire          bcast_on  = armed_on && a_write && !sel_off;
  wire          bcast_off = armed_off && a_write && sel_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_on  <= 1'b0;
      armed_off <= 1'b0;
    end else begin
      if (arm_on) armed_on <= 1'b1;
      else if (bcast_on) armed_on <= 1'b0;
      if (arm_off) armed_off <= 1'b1;
      else if (bcast_off) armed_off <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire hit = host_wr && (wr_chan == CW'(c));
    wire wr_on  = (hit && !sel_off) || bcast_on;
    wire wr_off = (hit && sel_off) || bcast_off;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q[c]  <= '0;
        off_q[c] <= '0;
      end else begin
        if (ld_on) on_q[c] <= XON_DEF;
        else if (wr_on) on_q[c] <= host_wdata;
        if (ld_off) off_q[c] <= XOFF_DEF;
        else if (wr_off) off_q[c] <= host_wdata;
      end
    end

    assign xon_chars[c*DW +: DW]  = on_q[c];
    assign xoff_chars[c*DW +: DW] = off_q[c];
  end

  assign host_rdata = sel_off ? off_q[wr_chan] : on_q[wr_chan];
endmodule

module xonxoff_regfile_chk #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_DEF = 8'h11,
  parameter logic [DW-1:0] XOFF_DEF = 8'h13,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [AW-1:0]     host_addr,
  input logic [DW-1:0]     host_wdata,
  input logic              cmd_valid,
  input logic [CW-1:0]     cmd_chan,
  input logic [1:0]        cmd_op,
  input logic              armed_on,
  input logic              armed_off,
  input logic [NCH*DW-1:0] xon_chars,
  input logic [NCH*DW-1:0] xoff_chars
);
  wire cmd_a = cmd_valid && (cmd_chan == '0);

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a && cmd_op == 2'd0 |=> armed_on);

  p_bcast_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_on && host_wr && host_addr == '0 && !(cmd_a && cmd_op == 2'd2)
    |=> xon_chars == {NCH{$past(host_wdata)}});

  p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_off && host_wr && host_addr == AW'(1) && !(cmd_a && cmd_op == 2'd3)
    |=> xoff_chars == {NCH{$past(host_wdata)}});

  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_on && host_wr && host_addr == '0 && !(cmd_a && cmd_op == 2'd0) |=> !armed_on);

  p_load_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a && cmd_op == 2'd2 |=> xon_chars == {NCH{XON_DEF}} && $stable(armed_on) && $stable(armed_off));

  p_load_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a && cmd_op == 2'd3 |=> xoff_chars == {NCH{XOFF_DEF}});

  p_other_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_chan != '0 && !host_wr
    |=> $stable(xon_chars) && $stable(xoff_chars) && $stable(armed_on) && $stable(armed_off));
endmodule

bind xonxoff_regfile xonxoff_regfile_chk #(.NCH(NCH), .DW(DW), .XON_DEF(XON_DEF), .XOFF_DEF(XOFF_DEF)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_op(cmd_op), .armed_on(armed_on),
  .armed_off(armed_off), .xon_chars(xon_chars), .xoff_chars(xoff_chars));

// File: tb/tb_xonxoff_regfile.sv
module tb_xonxoff_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, cmd_valid = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [1:0] cmd_chan = '0, cmd_op = '0;
  logic [31:0] xon_chars, xoff_chars;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  xonxoff_regfile dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
    .cmd_chan(cmd_chan), .cmd_op(cmd_op), .xon_chars(xon_chars), .xoff_chars(xoff_chars));

  // {req, wr, addr, wdata, cmd_valid, cmd_chan, cmd_op, exp_xon, exp_xoff}
  localparam int NV = 18;
  localparam logic [84:0] VEC [NV] = '{
    {4'd2,  1'b1, 3'b010, 8'hA5, 1'b0, 2'd0, 2'd0, 32'h0000A500, 32'h00000000}, // R2
    {4'd2,  1'b1, 3'b101, 8'h5C, 1'b0, 2'd0, 2'd0, 32'h0000A500, 32'h005C0000}, // R2
    {4'd3,  1'b0, 3'b000, 8'h00, 1'b1, 2'd0, 2'd0, 32'h0000A500, 32'h005C0000}, // R3 arm
    {4'd6,  1'b1, 3'b110, 8'h77, 1'b0, 2'd0, 2'd0, 32'h7700A500, 32'h005C0000}, // R6
    {4'd7,  1'b1, 3'b001, 8'h3C, 1'b0, 2'd0, 2'd0, 32'h7700A500, 32'h005C003C}, // R7
    {4'd3,  1'b1, 3'b000, 8'h42, 1'b0, 2'd0, 2'd0, 32'h42424242, 32'h005C003C}, // R3 fire
    {4'd5,  1'b1, 3'b000, 8'h99, 1'b0, 2'd0, 2'd0, 32'h42424299, 32'h005C003C}, // R5
    {4'd10, 1'b0, 3'b000, 8'h00, 1'b1, 2'd2, 2'd2, 32'h42424299, 32'h005C003C}, // R10
    {4'd10, 1'b0, 3'b000, 8'h00, 1'b1, 2'd1, 2'd0, 32'h42424299, 32'h005C003C}, // R10
    {4'd10, 1'b1, 3'b000, 8'h10, 1'b0, 2'd0, 2'd0, 32'h42424210, 32'h005C003C}, // R10
    {4'd4,  1'b0, 3'b000, 8'h00, 1'b1, 2'd0, 2'd1, 32'h42424210, 32'h005C003C}, // R4 arm
    {4'd4,  1'b1, 3'b001, 8'hE7, 1'b0, 2'd0, 2'd0, 32'h42424210, 32'hE7E7E7E7}, // R4 fire
    {4'd8,  1'b0, 3'b000, 8'h00, 1'b1, 2'd0, 2'd2, 32'h11111111, 32'hE7E7E7E7}, // R8
    {4'd9,  1'b1, 3'b101, 8'h55, 1'b1, 2'd0, 2'd3, 32'h11111111, 32'h13131313}, // R9
    {4'd11, 1'b1, 3'b010, 8'hAB, 1'b1, 2'd0, 2'd2, 32'h11111111, 32'h13131313}, // R11
    {4'd8,  1'b0, 3'b000, 8'h00, 1'b1, 2'd0, 2'd0, 32'h11111111, 32'h13131313}, // R8 arm
    {4'd8,  1'b0, 3'b000, 8'h00, 1'b1, 2'd0, 2'd2, 32'h11111111, 32'h13131313}, // R8 load
    {4'd8,  1'b1, 3'b000, 8'h66, 1'b0, 2'd0, 2'd0, 32'h66666666, 32'h13131313}  // R8 arm kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 1'b0; cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 xon reset", xon_chars, 32'h0);
    check("R1 xoff reset", xoff_chars, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] tag;
      logic [31:0] eon, eoff;
      {tag, host_wr, host_addr, host_wdata, cmd_valid, cmd_chan, cmd_op, eon, eoff} = VEC[i];
      @(negedge clk);
      check($sformatf("R%0d xon vec%0d", tag, i), xon_chars, eon);
      check($sformatf("R%0d xoff vec%0d", tag, i), xoff_chars, eoff);
    end
    idle();

    // R2 readback of every address
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a);
      #1;
      check($sformatf("R2 readback addr%0d", a), {24'h0, host_rdata}, a[0] ? 32'h13 : 32'h66);
    end

    // R1 reset clears a pending arm
    cmd_valid = 1'b1; cmd_chan = 2'd0; cmd_op = 2'd0;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 xon mid reset", xon_chars, 32'h0);
    check("R1 xoff mid reset", xoff_chars, 32'h0);
    rst_n = 1'b1;
    host_wr = 1'b1; host_addr = 3'b000; host_wdata = 8'h5A;
    @(negedge clk);
    idle();
    check("R1 individual after reset", xon_chars, 32'h0000005A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule